// File: doc/BRIEF.md
# Dual-Pump Phase Detector Controller

This block is the digital core of a phase-locked loop synthesizer. It divides a reference signal and a feedback signal by separately programmed ratios. It then compares the two divided outputs in a tri-state phase/frequency detector. The detector output drives two charge-pump channels. A normal channel runs whenever the block is powered. A speed-up channel adds loop gain while frequency is changing, and it is switched only at detector cycle boundaries so that a correction pulse is never cut.

Both input signals are sampled on the system clock. A divider counts rising edges, where a rising edge is a 0 in one clock sample followed by a 1 in the next. Power-down has two sources, one from a pin and one from a programmed bit. While either source is high, both dividers and the detector are held cleared. When power-down ends, the two dividers restart from zero together. The lock output is a pulse that lasts as long as the measured phase error, and a programmed bit can mask it.

Top module: `dual_pump_pfd`

## Requirements
- R1: The feedback divider emits one terminal count for every N sampled rising edges of `fb_in`, where N is `main_ratio`. Any value below 512 is used as 512, and the full 17-bit range up to 131071 is accepted.
- R2: The reference divider emits one terminal count for every M sampled rising edges of `ref_in`, where M is `ref_ratio`. A value of 0 is used as 1.
- R3: A divider terminal count is registered on the clock edge that samples the completing rising edge. On the next clock edge, a reference count sets `pump_up` and a feedback count sets `pump_dn`. If both would be high at once, both are low after that edge instead.
- R4: `norm_en` is high exactly when both `hw_pdn` and `sw_pdn` are low.
- R5: `fast_en` changes only on the clock edge that follows a reference terminal count, and then takes the value of `fast_req` sampled on that edge. `fast_up` equals `pump_up` AND `fast_en`, and `fast_dn` equals `pump_dn` AND `fast_en`.
- R6: While `hw_pdn` or `sw_pdn` is high, the divider counts, `pump_up`, `pump_dn` and `fast_en` are cleared on each clock edge. After both sources are low again, the two dividers count from zero together. So two identical input waveforms at equal ratios produce no detector pulse.
- R7: `lock_out` equals `pump_up` OR `pump_dn` while `lock_dis` is low, which makes it as wide as the phase error. It is held low while `lock_dis` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; both input signals are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference signal, synchronous to clk |
| fb_in | input | 1 | Feedback (VCO-derived) signal, synchronous to clk |
| ref_ratio | input | REF_W | Reference division ratio |
| main_ratio | input | MAIN_W | Feedback division ratio, minimum 512 |
| fast_req | input | 1 | Request for the speed-up pump |
| hw_pdn | input | 1 | Power-down from a pin |
| sw_pdn | input | 1 | Power-down from a programmed bit |
| lock_dis | input | 1 | Masks the lock pulse output |
| norm_en | output | 1 | Normal pump enable |
| fast_en | output | 1 | Speed-up pump enable |
| pump_up | output | 1 | Up command to the normal pump |
| pump_dn | output | 1 | Down command to the normal pump |
| fast_up | output | 1 | Up command to the speed-up pump |
| fast_dn | output | 1 | Down command to the speed-up pump |
| lock_out | output | 1 | Phase-error-wide lock pulse |

## Verification
Two events can fall on the same clock edge. A reference terminal count can coincide with a feedback terminal count, which must cancel both detector states. A `fast_req` change can coincide with the reference count that gates it. The first case is provoked by leaving power-down with identical reference and feedback waveforms at equal ratios. The bench then requires zero detector activity over several detector cycles. Random segments with changing ratios, toggle densities, `fast_req` flips and power-down bursts provoke both cases by chance. Each of these is judged every cycle against a bench model built from the requirements.

// File: rtl/dpp_pkg.sv
// Package: shared defaults for the dual-pump phase detector controller.
// Assumes: all users size their ports from these defaults.
package dpp_pkg;
    localparam int MAIN_W_DEF   = 17;   // feedback ratio width (max 131071)
    localparam int MAIN_MIN_DEF = 512;  // smallest usable feedback ratio
    localparam int REF_W_DEF    = 12;   // reference ratio width
    localparam int REF_MIN_DEF  = 1;    // smallest usable reference ratio
endpackage

// File: rtl/dpp_divider.sv
// Module: programmable edge-counting divider.
// Counts sampled rising edges of sig_in and emits a one-cycle registered
// terminal count every eff edges, eff being ratio clamped to MIN_RATIO.
// Assumes: sig_in is synchronous to clk; hold clears the count (power-down).
module dpp_divider #(
    parameter int W         = 17,
    parameter int MIN_RATIO = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         sig_in,
    input  logic [W-1:0] ratio,
    output logic         tc
);
    localparam logic [W-1:0] MIN_V = W'(MIN_RATIO);

    logic         prev;
    logic         rise;
    logic [W-1:0] cnt;
    logic [W-1:0] eff;

    assign eff  = (ratio < MIN_V) ? MIN_V : ratio;
    assign rise = sig_in & ~prev;

    // Keep the previous input sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sig_in;
    end

    // Count edges and emit the terminal count, cleared while held.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            cnt <= '0;
            tc  <= 1'b0;
        end else begin
            tc <= 1'b0;
            if (rise) begin
                if (({1'b0, cnt} + 1'b1) >= {1'b0, eff}) begin
                    cnt <= '0;
                    tc  <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);  // R1
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !tc);  // R6
endmodule

// File: rtl/dpp_pfd_core.sv
// Module: tri-state phase/frequency detector.
// A reference count sets up, a feedback count sets dn, and both clear
// together when both would be set. Held cleared during power-down.
module dpp_pfd_core (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn,
    input  logic ref_tc,
    input  logic fb_tc,
    output logic up,
    output logic dn
);
    logic up_nx;
    logic dn_nx;

    assign up_nx = up | ref_tc;
    assign dn_nx = dn | fb_tc;

    // Advance the detector state, cancelling when both sides are set.
    always_ff @(posedge clk) begin
        if (!rst_n || pdn) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else if (up_nx && dn_nx) begin
            up <= 1'b0;
            dn <= 1'b0;
        end else begin
            up <= up_nx;
            dn <= dn_nx;
        end
    end

    AST_NO_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && dn));  // R3
    AST_UP_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_tc && !fb_tc && !dn && !pdn) |=> up);  // R3
    AST_PDN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (!up && !dn));  // R6
endmodule

// File: rtl/dpp_pump_ctrl.sv
// Module: speed-up pump gating and lock pulse.
// fast_en follows fast_req only at reference terminal counts, so the
// speed-up pump never switches inside a correction pulse.
// Assumes: up/dn come from the detector and are already cleared in power-down.
module dpp_pump_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn,
    input  logic ref_tc,
    input  logic fast_req,
    input  logic up,
    input  logic dn,
    input  logic lock_dis,
    output logic fast_en,
    output logic fast_up,
    output logic fast_dn,
    output logic lock_out
);
    // Latch the speed-up request at a detector cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || pdn) fast_en <= 1'b0;
        else if (ref_tc)   fast_en <= fast_req;
    end

    // Gate the shared up/down commands onto the speed-up pump and lock pin.
    always_comb begin
        fast_up  = up & fast_en;
        fast_dn  = dn & fast_en;
        lock_out = (up | dn) & ~lock_dis;
    end

    AST_FAST_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_tc && !pdn) |=> $stable(fast_en));  // R5
endmodule

// File: rtl/dual_pump_pfd.sv
// Module: top of the dual-pump phase detector controller.
// Two dividers feed a tri-state detector whose commands drive a normal and
// a speed-up charge pump; a lock pulse mirrors the phase error.
// Assumes: ref_in and fb_in are synchronous to clk.
module dual_pump_pfd
    import dpp_pkg::*;
#(
    parameter int MAIN_W   = MAIN_W_DEF,
    parameter int MAIN_MIN = MAIN_MIN_DEF,
    parameter int REF_W    = REF_W_DEF,
    parameter int REF_MIN  = REF_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_in,
    input  logic              fb_in,
    input  logic [REF_W-1:0]  ref_ratio,
    input  logic [MAIN_W-1:0] main_ratio,
    input  logic              fast_req,
    input  logic              hw_pdn,
    input  logic              sw_pdn,
    input  logic              lock_dis,
    output logic              norm_en,
    output logic              fast_en,
    output logic              pump_up,
    output logic              pump_dn,
    output logic              fast_up,
    output logic              fast_dn,
    output logic              lock_out
);
    logic pdn;
    logic ref_tc;
    logic fb_tc;

    assign pdn     = hw_pdn | sw_pdn;
    assign norm_en = ~pdn;

    dpp_divider #(.W(REF_W), .MIN_RATIO(REF_MIN)) u_ref_div (
        .clk(clk), .rst_n(rst_n), .hold(pdn), .sig_in(ref_in),
        .ratio(ref_ratio), .tc(ref_tc)
    );

    dpp_divider #(.W(MAIN_W), .MIN_RATIO(MAIN_MIN)) u_main_div (
        .clk(clk), .rst_n(rst_n), .hold(pdn), .sig_in(fb_in),
        .ratio(main_ratio), .tc(fb_tc)
    );

    dpp_pfd_core u_pfd (
        .clk(clk), .rst_n(rst_n), .pdn(pdn), .ref_tc(ref_tc), .fb_tc(fb_tc),
        .up(pump_up), .dn(pump_dn)
    );

    dpp_pump_ctrl u_pump (
        .clk(clk), .rst_n(rst_n), .pdn(pdn), .ref_tc(ref_tc),
        .fast_req(fast_req), .up(pump_up), .dn(pump_dn), .lock_dis(lock_dis),
        .fast_en(fast_en), .fast_up(fast_up), .fast_dn(fast_dn),
        .lock_out(lock_out)
    );

    AST_PDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pdn |=> (!fast_en && !pump_up && !pump_dn));  // R6
    AST_LOCK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        lock_dis |-> !lock_out);  // R7
    AST_FAST_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_up || fast_dn) |-> (pump_up || pump_dn));  // R5
endmodule

// File: tb/tb_dual_pump_pfd.sv
module tb_dual_pump_pfd;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0, fb_in = 1'b0;
    logic [11:0] ref_ratio = 12'd300;
    logic [16:0] main_ratio = 17'd512;
    logic        fast_req = 1'b0, hw_pdn = 1'b0, sw_pdn = 1'b0, lock_dis = 1'b0;
    logic        norm_en, fast_en, pump_up, pump_dn, fast_up, fast_dn, lock_out;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    // bench model state
    int  m_rc = 0, m_fc = 0;
    bit  m_rtc = 0, m_ftc = 0, m_up = 0, m_dn = 0, m_fast = 0, m_pr = 0, m_pf = 0;

    always #2.5 clk = ~clk;

    dual_pump_pfd dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .ref_ratio(ref_ratio), .main_ratio(main_ratio), .fast_req(fast_req),
        .hw_pdn(hw_pdn), .sw_pdn(sw_pdn), .lock_dis(lock_dis),
        .norm_en(norm_en), .fast_en(fast_en), .pump_up(pump_up),
        .pump_dn(pump_dn), .fast_up(fast_up), .fast_dn(fast_dn),
        .lock_out(lock_out)
    );

    function automatic int eff_main(input logic [16:0] r);
        return (r < 17'd512) ? 512 : int'(r);   // R1 clamp
    endfunction
    function automatic int eff_ref(input logic [11:0] r);
        return (r == 12'd0) ? 1 : int'(r);      // R2 zero maps to one
    endfunction

    // Requirement model, advanced on each rising edge.
    always @(posedge clk) begin
        bit rr, rf, nu, nd, pdn;
        pdn = hw_pdn | sw_pdn;
        rr = ref_in & ~m_pr;
        rf = fb_in & ~m_pf;
        m_pr = ref_in;
        m_pf = fb_in;
        if (!rst_n) begin
            m_pr = 0; m_pf = 0; m_rc = 0; m_fc = 0;
            m_rtc = 0; m_ftc = 0; m_up = 0; m_dn = 0; m_fast = 0;
        end else if (pdn) begin
            m_rc = 0; m_fc = 0; m_rtc = 0; m_ftc = 0;
            m_up = 0; m_dn = 0; m_fast = 0;
        end else begin
            nu = m_up | m_rtc;
            nd = m_dn | m_ftc;
            if (m_rtc) m_fast = fast_req;
            if (nu && nd) begin m_up = 0; m_dn = 0; end
            else begin m_up = nu; m_dn = nd; end
            m_rtc = 0;
            if (rr) begin
                if (m_rc + 1 >= eff_ref(ref_ratio)) begin m_rc = 0; m_rtc = 1; end
                else m_rc = m_rc + 1;
            end
            m_ftc = 0;
            if (rf) begin
                if (m_fc + 1 >= eff_main(main_ratio)) begin m_fc = 0; m_ftc = 1; end
                else m_fc = m_fc + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model (called at negedge).
    task automatic compare_all();
        check("R3", "pump_up", pump_up, m_up);
        check("R3", "pump_dn", pump_dn, m_dn);
        check("R4", "norm_en", norm_en, ~(hw_pdn | sw_pdn));
        check("R5", "fast_en", fast_en, m_fast);
        check("R5", "fast_up", fast_up, m_up & m_fast);
        check("R5", "fast_dn", fast_dn, m_dn & m_fast);
        check("R7", "lock_out", lock_out, (m_up | m_dn) & ~lock_dis);
    endtask

    initial begin
        int pdn_left;
        int p_ref, p_fb;
        int act_cnt;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // reset state
        check("R6", "reset pump_up", pump_up, 1'b0);
        check("R6", "reset pump_dn", pump_dn, 1'b0);
        check("R5", "reset fast_en", fast_en, 1'b0);
        check("R7", "reset lock_out", lock_out, 1'b0);
        rst_n = 1'b1;

        // Directed R6/R3: identical waveforms after power-down give no pulse.
        ref_ratio = 12'd512; main_ratio = 17'd512; hw_pdn = 1'b1;
        repeat (5) @(negedge clk);
        hw_pdn = 1'b0;
        act_cnt = 0;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            compare_all();
            if (pump_up || pump_dn) act_cnt++;
            ref_in = ~ref_in; fb_in = ref_in;
        end
        check("R6", "realigned dividers produce no pulse", act_cnt != 0, 1'b0);

        // Directed R1 clamp: ratio 3 behaves as 512 (model compares each cycle).
        main_ratio = 17'd3; ref_ratio = 12'd0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            compare_all();
            ref_in = ($urandom % 64 == 0) ? ~ref_in : ref_in;
            fb_in = ~fb_in;
        end

        // Random segments.
        pdn_left = 0;
        for (int s = 0; s < 55; s++) begin
            ref_ratio = 12'(100 + $urandom % 300);
            case ($urandom % 4)
                0: main_ratio = 17'($urandom % 512);
                1: main_ratio = 17'd512;
                default: main_ratio = 17'(512 + $urandom % 300);
            endcase
            p_ref = 2 + $urandom % 6;
            p_fb = 1 + $urandom % 2;
            fast_req = $urandom % 2;
            lock_dis = ($urandom % 4 == 0);
            for (int i = 0; i < 2000; i++) begin
                @(negedge clk);
                compare_all();
                if ($urandom % p_ref == 0) ref_in = ~ref_in;
                if ($urandom % p_fb == 0) fb_in = ~fb_in;
                if ($urandom % 300 == 0) fast_req = ~fast_req;
                if ($urandom % 700 == 0) lock_dis = ~lock_dis;
                if (pdn_left > 0) begin
                    pdn_left--;
                    if (pdn_left == 0) begin hw_pdn = 1'b0; sw_pdn = 1'b0; end
                end else if ($urandom % 2500 == 0) begin
                    pdn_left = 5 + $urandom % 20;
                    if ($urandom % 2 == 0) hw_pdn = 1'b1; else sw_pdn = 1'b1;
                end
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule